// File: doc/BRIEF.md
# Zone-Based Memory Access Map

This block keeps a compact access history for the last-level cache. It does not hold one shadow tag per cache line. It tracks whole address zones instead, and each zone spans a fixed number of consecutive lines. Each tracked zone sits in one way of a small set-associative table. An entry holds the zone tag, one touched bit per line and two small counters. The access counter counts every access to the zone. The reuse counter counts the accesses that land on a line already touched.

Every cache access is presented as a line address on a request strobe. The block finds the zone in its set and sets the line's touched bit. It answers one cycle later with four things: whether the zone was resident, whether the line had been touched before, and the zone's updated access and reuse counts. When the zone is not resident, the least recently used way of the set is reallocated. The new zone's touched bits are then wiped a slice at a time, and `busy` holds off new requests until the wipe is done. Consumers can read the ratio of reuse count to access count as a measure of spatial reuse around the line.

Top module: `zone_access_map`

## Requirements
- R1: The line address splits into fields from low to high as follows. The low `log2(ZONE_LINES)` bits select the line within the zone. The next `SET_W` bits select the set. The top `TAG_W` bits form the zone tag. The default widths are 8, 4 and 30.
- R2: An accepted request (`req_valid` high while `busy` is low) produces exactly one response with `rsp_valid` high on the next cycle. In every other cycle `rsp_valid` is low.
- R3: `rsp_map_hit` is 1 when the zone tag is resident in the addressed set and 0 otherwise.
- R4: On a map hit, `rsp_reuse` is 1 when the line was touched earlier while the zone was resident, and 0 on its first touch. Either way, the line is left touched.
- R5: On a map miss, the zone takes a way of its set, with all of its lines untouched except the current one. The response reports `rsp_reuse`=0, an access count of 1 and a reuse count of 0. No state is carried over from any zone that held the way before.
- R6: After a miss response, `busy` stays high for exactly `ZONE_LINES/CLEAR_BITS` cycles, starting in the cycle of that response. A request presented while `busy` is high is dropped: it gets no response and changes no zone.
- R7: On a map hit, the access count goes up by one. The reuse count goes up by one only when `rsp_reuse` is 1. The response carries the updated values.
- R8: If an update would make either count equal to `2^CNT_W-1`, both counts are stored halved (rounded down) instead, and the response shows the halved values.
- R9: A miss fills an empty way of the set first. When the set is full, it evicts the zone accessed least recently in that set.
- R10: Zones in different sets never evict one another.
- R11: After reset, `busy` and `rsp_valid` are low and every way is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request strobe |
| req_line_addr | input | TAG_W+SET_W+log2(ZONE_LINES) | Line address of the access |
| busy | output | 1 | Allocation wipe in progress; requests are dropped |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_map_hit | output | 1 | Zone was resident |
| rsp_reuse | output | 1 | Line had been touched before |
| rsp_access_cnt | output | CNT_W | Zone access count after the update |
| rsp_reuse_cnt | output | CNT_W | Zone reuse count after the update |

## Verification
The bench builds the block with 2 sets of 2 ways, 16-line zones, 4-bit counters and a 4-line wipe slice. Two ways per set let a handful of zones force LRU evictions and the reallocation of an evicted zone. The 4-bit counters reach their saturation point, where both values are halved, within about fifteen accesses. The four-cycle wipe leaves room to inject a dropped request while `busy` is high and to measure the busy window.

// File: rtl/zam_pkg.sv
package zam_pkg;

    typedef enum logic [0:0] {
        ZAM_IDLE  = 1'b0,
        ZAM_CLEAR = 1'b1
    } zam_mode_e;

endpackage

// File: rtl/zam_way_match.sv
// Tag compare across the ways of one set, plus the replacement choice.
module zam_way_match #(
    parameter int WAYS  = 12,
    parameter int TAG_W = 30,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [WAYS-1:0][WAY_W-1:0] set_ages,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           victim_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && (set_tags[w] == probe_tag);
    end

    always_comb begin
        logic             have_free;
        logic [WAY_W-1:0] free_way;
        logic [WAY_W-1:0] oldest_way;

        hit        = |match;
        hit_way    = '0;
        have_free  = 1'b0;
        free_way   = '0;
        oldest_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
            end
            if (!set_valid[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
            if (set_ages[w] == WAY_W'(WAYS - 1)) begin
                oldest_way = WAY_W'(w);
            end
        end
        victim_way = have_free ? free_way : oldest_way;
    end

endmodule

// File: rtl/zam_age_update.sv
// Recency ages form a permutation per set; the used way becomes youngest.
module zam_age_update #(
    parameter int WAYS = 12,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
    input  logic [WAY_W-1:0]           used_way,
    output logic [WAYS-1:0][WAY_W-1:0] ages_out
);

    logic [WAY_W-1:0] used_age;

    assign used_age = ages_in[used_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == used_way) begin
                ages_out[w] = '0;
            end else if (ages_in[w] < used_age) begin
                ages_out[w] = ages_in[w] + 1'b1;
            end else begin
                ages_out[w] = ages_in[w];
            end
        end
    end

endmodule

// File: rtl/zam_count_update.sv
// Access/reuse counter step with ratio-preserving halving at the top value.
module zam_count_update #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] acc_in,
    input  logic [CNT_W-1:0] reu_in,
    input  logic             restart,
    input  logic             reuse,
    output logic [CNT_W-1:0] acc_out,
    output logic [CNT_W-1:0] reu_out
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] acc_base;
    logic [CNT_W-1:0] reu_base;
    logic [CNT_W-1:0] acc_inc;
    logic [CNT_W-1:0] reu_inc;
    logic             at_top;

    always_comb begin
        acc_base = restart ? '0 : acc_in;
        reu_base = restart ? '0 : reu_in;
        acc_inc  = acc_base + 1'b1;
        reu_inc  = reu_base + CNT_W'(reuse);
        at_top   = (acc_inc == CNT_TOP) || (reu_inc == CNT_TOP);
        acc_out  = at_top ? (acc_inc >> 1) : acc_inc;
        reu_out  = at_top ? (reu_inc >> 1) : reu_inc;
    end

endmodule

// File: rtl/zone_access_map.sv
module zone_access_map
    import zam_pkg::*;
#(
    parameter int TAG_W      = 30,
    parameter int SET_W      = 4,
    parameter int ZONE_LINES = 256,
    parameter int WAYS       = 12,
    parameter int CNT_W      = 8,
    parameter int CLEAR_BITS = 64
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    input  logic [TAG_W+SET_W+$clog2(ZONE_LINES)-1:0]   req_line_addr,
    output logic                                        busy,
    output logic                                        rsp_valid,
    output logic                                        rsp_map_hit,
    output logic                                        rsp_reuse,
    output logic [CNT_W-1:0]                            rsp_access_cnt,
    output logic [CNT_W-1:0]                            rsp_reuse_cnt
);

    localparam int LINE_W      = $clog2(ZONE_LINES);
    localparam int SETS        = 1 << SET_W;
    localparam int WAY_W       = $clog2(WAYS);
    localparam int CLR_SH      = $clog2(CLEAR_BITS);
    localparam int CLEAR_STEPS = ZONE_LINES / CLEAR_BITS;

    typedef struct packed {
        zam_mode_e         mode;
        logic [LINE_W-1:0] step;
        logic [SET_W-1:0]  p_set;
        logic [WAY_W-1:0]  p_way;
        logic [LINE_W-1:0] p_line;
        logic              rsp_valid;
        logic              rsp_hit;
        logic              rsp_reuse;
        logic [CNT_W-1:0]  rsp_acc;
        logic [CNT_W-1:0]  rsp_reu;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WAYS-1:0][TAG_W-1:0]      tag_d [SETS];
    logic [WAYS-1:0][TAG_W-1:0]      tag_q [SETS];
    logic [WAYS-1:0]                 vld_d [SETS];
    logic [WAYS-1:0]                 vld_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]      age_d [SETS];
    logic [WAYS-1:0][WAY_W-1:0]      age_q [SETS];
    logic [WAYS-1:0][CNT_W-1:0]      acc_d [SETS];
    logic [WAYS-1:0][CNT_W-1:0]      acc_q [SETS];
    logic [WAYS-1:0][CNT_W-1:0]      reu_d [SETS];
    logic [WAYS-1:0][CNT_W-1:0]      reu_q [SETS];
    logic [WAYS-1:0][ZONE_LINES-1:0] map_d [SETS];
    logic [WAYS-1:0][ZONE_LINES-1:0] map_q [SETS];

    // Field split of the incoming line address.
    logic [LINE_W-1:0] req_line;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;

    assign req_line = req_line_addr[0 +: LINE_W];
    assign req_set  = req_line_addr[LINE_W +: SET_W];
    assign req_tag  = req_line_addr[LINE_W+SET_W +: TAG_W];

    // Lookup in the addressed set.
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_hit_way;
    logic [WAY_W-1:0]            lk_victim;
    logic [WAY_W-1:0]            sel_way;
    logic                        line_seen;
    logic [CNT_W-1:0]            cnt_acc;
    logic [CNT_W-1:0]            cnt_reu;
    logic [WAYS-1:0][WAY_W-1:0]  age_next;
    logic                        accept;

    zam_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .set_tags   (tag_q[req_set]),
        .set_valid  (vld_q[req_set]),
        .set_ages   (age_q[req_set]),
        .probe_tag  (req_tag),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .victim_way (lk_victim)
    );

    assign sel_way   = lk_hit ? lk_hit_way : lk_victim;
    assign line_seen = lk_hit && map_q[req_set][lk_hit_way][req_line];
    assign accept    = req_valid && (ctl_q.mode == ZAM_IDLE);

    zam_count_update #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .acc_in  (acc_q[req_set][sel_way]),
        .reu_in  (reu_q[req_set][sel_way]),
        .restart (!lk_hit),
        .reuse   (line_seen),
        .acc_out (cnt_acc),
        .reu_out (cnt_reu)
    );

    zam_age_update #(
        .WAYS (WAYS)
    ) u_age (
        .ages_in  (age_q[req_set]),
        .used_way (sel_way),
        .ages_out (age_next)
    );

    // Next-state computation.
    always_comb begin
        logic [LINE_W-1:0] clr_base;

        ctl_d = ctl_q;
        tag_d = tag_q;
        vld_d = vld_q;
        age_d = age_q;
        acc_d = acc_q;
        reu_d = reu_q;
        map_d = map_q;

        ctl_d.rsp_valid = 1'b0;
        clr_base        = LINE_W'(ctl_q.step << CLR_SH);

        if (ctl_q.mode == ZAM_CLEAR) begin
            // Wipe one slice of the freshly allocated bitmap per cycle.
            map_d[ctl_q.p_set][ctl_q.p_way][clr_base +: CLEAR_BITS] = '0;
            if ((ctl_q.p_line >> CLR_SH) == ctl_q.step) begin
                map_d[ctl_q.p_set][ctl_q.p_way][ctl_q.p_line] = 1'b1;
            end
            if (ctl_q.step == LINE_W'(CLEAR_STEPS - 1)) begin
                ctl_d.mode = ZAM_IDLE;
                ctl_d.step = '0;
            end else begin
                ctl_d.step = ctl_q.step + 1'b1;
            end
        end else if (accept) begin
            acc_d[req_set][sel_way] = cnt_acc;
            reu_d[req_set][sel_way] = cnt_reu;
            age_d[req_set]          = age_next;

            ctl_d.rsp_valid = 1'b1;
            ctl_d.rsp_hit   = lk_hit;
            ctl_d.rsp_reuse = line_seen;
            ctl_d.rsp_acc   = cnt_acc;
            ctl_d.rsp_reu   = cnt_reu;

            if (lk_hit) begin
                map_d[req_set][sel_way][req_line] = 1'b1;
            end else begin
                tag_d[req_set][sel_way] = req_tag;
                vld_d[req_set][sel_way] = 1'b1;
                ctl_d.mode              = ZAM_CLEAR;
                ctl_d.step              = '0;
                ctl_d.p_set             = req_set;
                ctl_d.p_way             = sel_way;
                ctl_d.p_line            = req_line;
            end
        end
    end

    // Control, valid bits and recency ages are reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            ctl_q <= ctl_d;
            vld_q <= vld_d;
            age_q <= age_d;
        end
    end

    // Payload storage is written on allocation, so it carries no reset.
    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        acc_q <= acc_d;
        reu_q <= reu_d;
        map_q <= map_d;
    end

    assign busy           = (ctl_q.mode == ZAM_CLEAR);
    assign rsp_valid      = ctl_q.rsp_valid;
    assign rsp_map_hit    = ctl_q.rsp_hit;
    assign rsp_reuse      = ctl_q.rsp_reuse;
    assign rsp_access_cnt = ctl_q.rsp_acc;
    assign rsp_reuse_cnt  = ctl_q.rsp_reu;

endmodule

// File: rtl/zam_checker.sv
module zam_checker #(
    parameter int CNT_W       = 8,
    parameter int CLEAR_STEPS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_map_hit,
    input logic             rsp_reuse,
    input logic [CNT_W-1:0] rsp_access_cnt,
    input logic [CNT_W-1:0] rsp_reuse_cnt
);

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R2: accepted request answered on the next cycle
    a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> rsp_valid);

    // R2: no response without an accepted request
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !busy) |=> !rsp_valid);

    // R6: a request seen while busy is dropped
    a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);

    // R6: a miss response coincides with the start of the wipe
    a_r6_miss_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_map_hit) |-> busy);

    // R6: the wipe window never exceeds its slice count
    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CLEAR_STEPS));

    // R5: a fresh allocation reports a first touch
    a_r5_miss_fresh_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_map_hit) |->
            (!rsp_reuse && rsp_access_cnt == CNT_W'(1) && rsp_reuse_cnt == '0));

    // R4: reuse can only be reported for a resident zone
    a_r4_reuse_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reuse) |-> rsp_map_hit);

    // R8: halving keeps reuse at or below accesses and accesses nonzero
    a_r8_count_order: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_reuse_cnt <= rsp_access_cnt && rsp_access_cnt != '0));

endmodule

bind zone_access_map zam_checker #(
    .CNT_W       (CNT_W),
    .CLEAR_STEPS (ZONE_LINES / CLEAR_BITS)
) u_zam_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .busy           (busy),
    .rsp_valid      (rsp_valid),
    .rsp_map_hit    (rsp_map_hit),
    .rsp_reuse      (rsp_reuse),
    .rsp_access_cnt (rsp_access_cnt),
    .rsp_reuse_cnt  (rsp_reuse_cnt)
);

// File: tb/zone_access_map_test.sv
`timescale 1ns/1ps
module zone_access_map_test;

    localparam int TAG_W      = 6;
    localparam int SET_W      = 1;
    localparam int ZONE_LINES = 16;
    localparam int WAYS       = 2;
    localparam int CNT_W      = 4;
    localparam int CLEAR_BITS = 4;
    localparam int ADDR_W     = TAG_W + SET_W + 4;
    localparam int CNT_TOP    = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_line_addr = '0;
    logic              busy;
    logic              rsp_valid;
    logic              rsp_map_hit;
    logic              rsp_reuse;
    logic [CNT_W-1:0]  rsp_access_cnt;
    logic [CNT_W-1:0]  rsp_reuse_cnt;

    always #5 clk = ~clk;

    zone_access_map #(
        .TAG_W(TAG_W), .SET_W(SET_W), .ZONE_LINES(ZONE_LINES),
        .WAYS(WAYS), .CNT_W(CNT_W), .CLEAR_BITS(CLEAR_BITS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_line_addr(req_line_addr), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_map_hit(rsp_map_hit), .rsp_reuse(rsp_reuse),
        .rsp_access_cnt(rsp_access_cnt), .rsp_reuse_cnt(rsp_reuse_cnt)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    hit;
        bit    reuse;
        int    acc;
        int    reu;
        string req;
    } exp_t;

    exp_t exp_q[$];

    // Reference model: slots per set, recency stamps, bitmaps, counters.
    bit          m_valid [2][2];
    int          m_tag   [2][2];
    logic [15:0] m_bm    [2][2];
    int          m_acc   [2][2];
    int          m_reu   [2][2];
    int          m_stamp [2][2];
    int          tnow = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(input int tag, input int set, input int line, input string req);
        exp_t e;
        int   slot = -1;
        tnow++;
        e.req = req;
        for (int i = 0; i < WAYS; i++)
            if (m_valid[set][i] && m_tag[set][i] == tag) slot = i;
        if (slot >= 0) begin
            e.hit   = 1'b1;
            e.reuse = m_bm[set][slot][line];
            m_bm[set][slot][line] = 1'b1;
            m_acc[set][slot] += 1;
            if (e.reuse) m_reu[set][slot] += 1;
            if (m_acc[set][slot] == CNT_TOP || m_reu[set][slot] == CNT_TOP) begin
                m_acc[set][slot] = m_acc[set][slot] / 2;
                m_reu[set][slot] = m_reu[set][slot] / 2;
            end
        end else begin
            for (int i = WAYS - 1; i >= 0; i--)
                if (!m_valid[set][i]) slot = i;
            if (slot < 0) begin
                slot = 0;
                for (int i = 1; i < WAYS; i++)
                    if (m_stamp[set][i] < m_stamp[set][slot]) slot = i;
            end
            e.hit = 1'b0;
            e.reuse = 1'b0;
            m_valid[set][slot] = 1'b1;
            m_tag[set][slot]   = tag;
            m_bm[set][slot]    = 16'h0;
            m_bm[set][slot][line] = 1'b1;
            m_acc[set][slot]   = 1;
            m_reu[set][slot]   = 0;
        end
        m_stamp[set][slot] = tnow;
        e.acc = m_acc[set][slot];
        e.reu = m_reu[set][slot];
        exp_q.push_back(e);
    endtask

    // Driver: waits out busy, records expectation, presents one request.
    task automatic access(input int tag, input int set, input int line, input string req);
        while (busy) @(negedge clk);
        model(tag, set, line, req);
        req_valid     = 1'b1;
        req_line_addr = {TAG_W'(tag), SET_W'(set), 4'(line)};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares every response against the queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_map_hit == e.hit, e.req, "map hit", rsp_map_hit, e.hit);
                chk(rsp_reuse == e.reuse, e.req, "reuse flag", rsp_reuse, e.reuse);
                chk(int'(rsp_access_cnt) == e.acc, e.req, "access count",
                    rsp_access_cnt, e.acc);
                chk(int'(rsp_reuse_cnt) == e.reu, e.req, "reuse count",
                    rsp_reuse_cnt, e.reu);
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run expired", 1, 0);
        finish_up();
    end

    initial begin
        int busy_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);

        // R3 R5: first zone misses into an empty set
        access(5, 0, 3, "R5");
        busy_len = 0;
        while (busy) begin
            busy_len++;
            @(negedge clk);
        end
        // R6: wipe window length
        chk(busy_len == ZONE_LINES / CLEAR_BITS, "R6", "busy cycles", busy_len,
            ZONE_LINES / CLEAR_BITS);

        access(5, 0, 3, "R4");   // R4 R7: reuse of a touched line
        access(5, 0, 4, "R7");   // R7: first touch in a resident zone
        access(5, 0, 4, "R4");
        access(6, 0, 3, "R1");   // R1: tag field distinguishes zones
        access(7, 1, 3, "R10");  // R10: other set
        access(5, 0, 3, "R10");  // R10: set 0 zone untouched by set 1
        access(6, 0, 3, "R4");
        access(8, 0, 0, "R9");   // R9: evicts zone 5 (least recent)
        access(6, 0, 0, "R9");   // R9: zone 6 stayed
        access(5, 0, 3, "R5");   // R5: zone 5 back with fresh state
        access(5, 0, 4, "R5");   // R5: old touch of line 4 is gone
        access(5, 0, 15, "R1");  // R1: top line of the zone

        // R6: request while busy is dropped
        access(10, 1, 2, "R5");
        chk(busy == 1'b1, "R6", "busy after miss", busy, 1);
        req_valid     = 1'b1;
        req_line_addr = {TAG_W'(9), SET_W'(0), 4'(1)};
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R6", "response to dropped request", rsp_valid, 0);
        access(6, 0, 0, "R6");   // still resident: dropped request evicted nothing
        access(5, 0, 3, "R6");

        // R8: counter halving in a new set 1 zone (evicts zone 7)
        for (int i = 0; i < 22; i++) begin
            access(11, 1, i % 5, "R8");
        end
        access(7, 1, 0, "R9");   // R9: zone 7 was evicted, zone 10 now oldest

        repeat (6) @(negedge clk);
        // R2: every request answered
        chk(exp_q.size() == 0, "R2", "pending responses", exp_q.size(), 0);
        finish_up();
    end

endmodule